// File: doc/BRIEF.md
# Accumulator ALU Instruction Group

This block executes the six accumulator arithmetic and logic instructions of a classic 8-bit microprocessor: bitwise OR, AND and exclusive-OR, add with carry, subtract with carry, and compare. The core supplies an opcode byte, the operand byte that has already been fetched, and the current accumulator and status register. It pulses a start strobe. One clock later the block returns the new accumulator and status values with a done strobe. The core writes those values back.

A combinational output reports the addressing mode that the opcode selects, so the address unit can fetch the operand before execution starts. Each operation owns eight opcodes. An opcode outside these 48 codes is flagged as foreign: the accumulator and status pass through untouched and the rest of the core dispatches the instruction elsewhere. Arithmetic is always binary. The decimal-mode flag is carried through and has no effect.

Top module: `accalu_unit`

## Requirements
- R1: An opcode belongs to the group exactly when bits [1:0] are 01 and bits [7:5] are not 100 or 101 (48 codes). Any other opcode sets `foreign_o`=1 in the result and returns `acc_o`=`acc_i` and `flags_o`=`flags_i`. Group opcodes give `foreign_o`=0.
- R2: `mode_o` is combinational from opcode bits [4:2]. Low five bits 0x09 give 0 (immediate), 0x05 give 1 (zero page), 0x15 give 2 (zero page + X), 0x0D give 3 (absolute), 0x1D give 4 (absolute + X), 0x19 give 5 (absolute + Y), 0x01 give 6 (indexed indirect), and 0x11 give 7 (indirect indexed).
- R3: `done_o` is high in the cycle after each cycle with `start_i` high, and low otherwise. The result outputs change only then and hold their value between results.
- R4: Opcode bits [7:5] select the operation: 000 OR, 001 AND, 010 exclusive-OR, 011 add with carry, 110 compare, 111 subtract with carry. The three logical operations write A op M to the accumulator.
- R5: The status bits are C=bit 0, Z=bit 1, V=bit 6 and N=bit 7. After OR, AND or exclusive-OR, Z and N follow the new accumulator, and C and V are unchanged.
- R6: Add with carry writes the low 8 bits of A+M+C. It sets C to the ninth bit, and sets Z and N from the result.
- R7: Subtract with carry writes A-M-(1-C). C=1 means no borrow occurred. Z and N are set from the result.
- R8: Add and subtract set V when the two effective addends have the same sign and the result sign differs. Otherwise they clear V.
- R9: Compare leaves the accumulator unchanged. It sets C when A>=M (unsigned), sets Z when A=M, sets N to bit 7 of A-M, and keeps V.
- R10: Status bits [5:2], including the decimal flag (bit 3), pass through unchanged. Setting the decimal flag does not change any arithmetic result.
- R11: After reset, `done_o`, `foreign_o`, `acc_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Execute the presented opcode this cycle |
| opcode_i | input | 8 | Instruction opcode byte |
| operand_i | input | 8 | Fetched operand byte M |
| acc_i | input | 8 | Current accumulator |
| flags_i | input | 8 | Current status register |
| mode_o | output | 3 | Addressing mode selected by the opcode |
| done_o | output | 1 | Result valid strobe |
| foreign_o | output | 1 | Opcode is outside this group |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 8 | New status register |

## Verification
The hardest cases to reach are the edges of the carry and overflow chain. These include subtraction with carry clear, which borrows one extra; a signed overflow in subtraction, where the operand signs differ; and compare at exactly A=M. Directed vectors hit each of these edges. The foreign codes that share the group's low bits (tops 100 and 101) are covered by a sweep of all 256 opcodes against two operand patterns. A scoreboard queue matches every result against a reference model that works from signed and unsigned sums rather than from the carry chain.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;

    // status bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_V = 6;
    localparam int FL_N = 7;

    typedef enum logic [2:0] {
        OPK_OR  = 3'd0,
        OPK_AND = 3'd1,
        OPK_XOR = 3'd2,
        OPK_ADD = 3'd3,
        OPK_CMP = 3'd6,
        OPK_SUB = 3'd7
    } opk_e;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 3'd0,
        AM_ZP   = 3'd1,
        AM_ZPX  = 3'd2,
        AM_ABS  = 3'd3,
        AM_ABSX = 3'd4,
        AM_ABSY = 3'd5,
        AM_INDX = 3'd6,
        AM_INDY = 3'd7
    } amode_e;

    typedef struct packed {
        logic              done;
        logic              foreign;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] flags;
    } res_regs_t;
endpackage

// File: rtl/accalu_decode.sv
module accalu_decode
    import accalu_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       hit,
    output opk_e       kind,
    output amode_e     mode
);
    logic [2:0] top_bits;
    logic       low_ok;
    logic       top_ok;

    assign top_bits = opcode[7:5];
    assign low_ok   = (opcode[1:0] == 2'b01);

    always_comb begin
        top_ok = 1'b1;
        kind   = OPK_OR;
        unique case (top_bits)
            3'b000: kind = OPK_OR;
            3'b001: kind = OPK_AND;
            3'b010: kind = OPK_XOR;
            3'b011: kind = OPK_ADD;
            3'b110: kind = OPK_CMP;
            3'b111: kind = OPK_SUB;
            default: top_ok = 1'b0;
        endcase
    end

    assign hit = low_ok & top_ok;

    always_comb begin
        unique case (opcode[4:2])
            3'b000: mode = AM_INDX;
            3'b001: mode = AM_ZP;
            3'b010: mode = AM_IMM;
            3'b011: mode = AM_ABS;
            3'b100: mode = AM_INDY;
            3'b101: mode = AM_ZPX;
            3'b110: mode = AM_ABSY;
            default: mode = AM_ABSX;
        endcase
    end
endmodule

// File: rtl/accalu_adder.sv
module accalu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_msb_in
);
    logic [W:0] cy;
    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p        = a[i] ^ b[i];
        assign sum[i]   = p ^ cy[i];
        assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & p);
    end

    assign cout     = cy[W];
    assign c_msb_in = cy[W-1];
endmodule

// File: rtl/accalu_exec.sv
module accalu_exec
    import accalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  opk_e         kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         v_out
);
    logic [W-1:0] b_sel;
    logic         c_sel;
    logic [W-1:0] sum;
    logic         cout;
    logic         c_msb;

    always_comb begin
        unique case (kind)
            OPK_ADD: begin b_sel = m;  c_sel = cin;  end
            OPK_SUB: begin b_sel = ~m; c_sel = cin;  end
            OPK_CMP: begin b_sel = ~m; c_sel = 1'b1; end
            default: begin b_sel = m;  c_sel = 1'b0; end
        endcase
    end

    accalu_adder #(.W(W)) u_add (
        .a        (a),
        .b        (b_sel),
        .cin      (c_sel),
        .sum      (sum),
        .cout     (cout),
        .c_msb_in (c_msb)
    );

    always_comb begin
        unique case (kind)
            OPK_OR:  res = a | m;
            OPK_AND: res = a & m;
            OPK_XOR: res = a ^ m;
            default: res = sum;
        endcase
    end

    assign c_out = cout;
    assign v_out = cout ^ c_msb;
endmodule

// File: rtl/accalu_unit.sv
module accalu_unit
    import accalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] flags_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              done_o,
    output logic              foreign_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] flags_o
);
    logic         dec_hit;
    opk_e         dec_kind;
    amode_e       dec_mode;
    logic [DATA_W-1:0] ex_res;
    logic         ex_c;
    logic         ex_v;

    res_regs_t    regs_d;
    res_regs_t    regs_q;

    accalu_decode u_dec (
        .opcode (opcode_i),
        .hit    (dec_hit),
        .kind   (dec_kind),
        .mode   (dec_mode)
    );

    accalu_exec #(.W(DATA_W)) u_exec (
        .kind  (dec_kind),
        .a     (acc_i),
        .m     (operand_i),
        .cin   (flags_i[FL_C]),
        .res   (ex_res),
        .c_out (ex_c),
        .v_out (ex_v)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = start_i;
        if (start_i) begin
            regs_d.flags   = flags_i;
            regs_d.acc     = acc_i;
            regs_d.foreign = ~dec_hit;
            if (dec_hit) begin
                regs_d.flags[FL_Z] = (ex_res == '0);
                regs_d.flags[FL_N] = ex_res[DATA_W-1];
                unique case (dec_kind)
                    OPK_ADD, OPK_SUB: begin
                        regs_d.acc         = ex_res;
                        regs_d.flags[FL_C] = ex_c;
                        regs_d.flags[FL_V] = ex_v;
                    end
                    OPK_CMP: begin
                        regs_d.flags[FL_C] = ex_c;
                    end
                    default: begin
                        regs_d.acc = ex_res;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode_o    = dec_mode;
    assign done_o    = regs_q.done;
    assign foreign_o = regs_q.foreign;
    assign acc_o     = regs_q.acc;
    assign flags_o   = regs_q.flags;
endmodule

// File: rtl/accalu_checks.sv
module accalu_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] opcode_i,
    input logic [7:0] acc_i,
    input logic [7:0] flags_i,
    input logic [2:0] mode_o,
    input logic       done_o,
    input logic       foreign_o,
    input logic [7:0] acc_o,
    input logic [7:0] flags_o
);
    a_r3_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && $stable(acc_o) && $stable(flags_o)));

    a_r1_foreign_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && foreign_o) |-> (acc_o == $past(acc_i) && flags_o == $past(flags_i)));

    a_r9_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(opcode_i[7:5] == 3'b110 && opcode_i[1:0] == 2'b01))
        |-> (acc_o == $past(acc_i) && flags_o[6] == $past(flags_i[6])));

    a_r5_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !foreign_o && $past(opcode_i[7] == 1'b0 && opcode_i[6:5] != 2'b11))
        |-> (flags_o[0] == $past(flags_i[0]) && flags_o[6] == $past(flags_i[6])));

    a_r5_zn_track_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !foreign_o && !$past(opcode_i[7:5] == 3'b110))
        |-> (flags_o[1] == (acc_o == 8'h00) && flags_o[7] == acc_o[7]));

    a_r10_mid_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o[5:2] == $past(flags_i[5:2])));

    a_r2_immediate_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i[4:0] == 5'h09) |-> (mode_o == 3'd0));
endmodule

bind accalu_unit accalu_checks u_accalu_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .opcode_i  (opcode_i),
    .acc_i     (acc_i),
    .flags_i   (flags_i),
    .mode_o    (mode_o),
    .done_o    (done_o),
    .foreign_o (foreign_o),
    .acc_o     (acc_o),
    .flags_o   (flags_o)
);

// File: tb/accalu_unit_bench.sv
module accalu_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] operand_i = 8'h00;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] flags_i = 8'h00;
    logic [2:0] mode_o;
    logic       done_o;
    logic       foreign_o;
    logic [7:0] acc_o;
    logic [7:0] flags_o;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] acc;
        logic [7:0] flags;
        logic       foreign;
        logic [7:0] op;
    } exp_t;

    exp_t sb_q[$];
    logic [7:0] last_acc = 8'h00;

    always #5 clk = ~clk;

    accalu_unit u_accalu_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .opcode_i  (opcode_i),
        .operand_i (operand_i),
        .acc_i     (acc_i),
        .flags_i   (flags_i),
        .mode_o    (mode_o),
        .done_o    (done_o),
        .foreign_o (foreign_o),
        .acc_o     (acc_o),
        .flags_o   (flags_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    function automatic exp_t model(input logic [7:0] op, input logic [7:0] m,
                                   input logic [7:0] a, input logic [7:0] p);
        exp_t e;
        int ua, um, uc, s, sa, sm, sr;
        logic [7:0] r;
        logic [2:0] top;
        top = op[7:5];
        e.op = op;
        e.acc = a;
        e.flags = p;
        e.foreign = 1'b1;
        if (op[1:0] != 2'b01 || top == 3'b100 || top == 3'b101) return e;
        e.foreign = 1'b0;
        ua = a; um = m; uc = p[0];
        sa = $signed(a); sm = $signed(m);
        r = a;
        case (top)
            3'b000: r = a | m;
            3'b001: r = a & m;
            3'b010: r = a ^ m;
            3'b011: begin
                s = ua + um + uc;
                r = s[7:0];
                e.flags[0] = (s > 255);
                sr = sa + sm + uc;
                e.flags[6] = (sr > 127 || sr < -128);
            end
            3'b110: begin
                s = ua - um;
                e.flags[0] = (ua >= um);
                e.flags[1] = (ua == um);
                e.flags[7] = s[7];
            end
            default: begin
                s = ua - um - (1 - uc);
                r = s[7:0];
                e.flags[0] = (s >= 0);
                sr = sa - sm - (1 - uc);
                e.flags[6] = (sr > 127 || sr < -128);
            end
        endcase
        if (top != 3'b110) begin
            e.acc = r;
            e.flags[1] = (r == 8'h00);
            e.flags[7] = r[7];
        end
        return e;
    endfunction

    function automatic int mode_of(input logic [4:0] lo);
        case (lo)
            5'h09: return 0;
            5'h05: return 1;
            5'h15: return 2;
            5'h0D: return 3;
            5'h1D: return 4;
            5'h19: return 5;
            5'h01: return 6;
            default: return 7;
        endcase
    endfunction

    // driver: called at a falling edge, returns at the next falling edge
    task automatic issue(input logic [7:0] op, input logic [7:0] m,
                         input logic [7:0] a, input logic [7:0] p);
        sb_q.push_back(model(op, m, a, p));
        opcode_i = op; operand_i = m; acc_i = a; flags_i = p;
        start_i = 1'b1;
        #1;
        if (op[1:0] == 2'b01 && op[7:5] != 3'b100 && op[7:5] != 3'b101)
            check(int'(mode_o) == mode_of(op[4:0]), "R2 mode", mode_o, mode_of(op[4:0]));
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(foreign_o == e.foreign, "R1 foreign", foreign_o, e.foreign);
                check(acc_o == e.acc, "R4/R6/R7/R9 acc", acc_o, e.acc);
                check(flags_o == e.flags, "R5/R6/R7/R8/R9/R10 flags", flags_o, e.flags);
                last_acc = e.acc;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(done_o == 1'b0 && foreign_o == 1'b0, "R11 strobes", {done_o, foreign_o}, 0);
        check(acc_o == 8'h00 && flags_o == 8'h00, "R11 data", {acc_o, flags_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 adding 0x10 to 0x01 with carry clear gives 0x11
        issue(8'h69, 8'h10, 8'h01, 8'h00);
        issue(8'h69, 8'h50, 8'h50, 8'h00);  // R8 overflow
        issue(8'h65, 8'h01, 8'hFF, 8'h00);  // R6 carry out, zero
        issue(8'h7D, 8'h01, 8'h01, 8'h01);  // R6 carry in
        // R10 decimal flag set, result stays binary: 0x09+0x01=0x0A
        issue(8'h69, 8'h01, 8'h09, 8'h08);
        // R7 subtract
        issue(8'hE9, 8'h03, 8'h05, 8'h01);
        issue(8'hE9, 8'h03, 8'h05, 8'h00);  // R7 borrow in
        issue(8'hE5, 8'hB0, 8'h50, 8'h01);  // R8 signed overflow on subtract
        issue(8'hF1, 8'h06, 8'h05, 8'h01);  // R7 borrow out
        // R9 compare: equal, less, greater; V preset kept
        issue(8'hC9, 8'h40, 8'h40, 8'h40);
        issue(8'hC5, 8'h41, 8'h40, 8'h00);
        issue(8'hDD, 8'h01, 8'h80, 8'h41);
        // R4/R5 logical ops with C and V preset
        issue(8'h09, 8'h0F, 8'hF0, 8'h41);
        issue(8'h29, 8'h0F, 8'hF0, 8'h41);
        issue(8'h49, 8'hFF, 8'h80, 8'h41);
        // R1 foreign codes
        issue(8'h89, 8'h12, 8'h34, 8'hC3);
        issue(8'hA9, 8'h12, 8'h34, 8'h3C);
        issue(8'h00, 8'h12, 8'h34, 8'hFF);

        // R3 idle cycle: done low, accumulator held
        @(negedge clk);
        check(done_o == 1'b0, "R3 idle done", done_o, 0);
        check(acc_o == last_acc, "R3 hold", acc_o, last_acc);

        // sweep all opcodes with two operand patterns
        for (int op = 0; op < 256; op++) begin
            issue(8'(op), 8'(op * 37 + 5), 8'(op * 11 + 128), 8'(op ^ 8'h5A));
            issue(8'(op), 8'(op), 8'(op), 8'(op ^ 8'hA5));
        end
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R3 drained", sb_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule